// File: doc/BRIEF.md
# Signed Multiply-Accumulate Unit with Read-and-Clear

This unit sits beside a processor's integer datapath and keeps a 64-bit accumulator, seen by software as two 32-bit words: the low word and the high word. An accumulate command multiplies two signed 32-bit operands. It keeps only the low 32 bits of the product as a signed value, sign-extends that value to 64 bits and adds it into the accumulator. A subtract command removes the same sign-extended value instead. Every command finishes in one clock, so an instruction that reads the accumulator directly after an accumulate needs no stall.

A read-and-clear command returns the current low word, unshifted, on a registered result port. In the same clock it zeroes both words. Software can also replace the low word or the high word directly. The two words are always visible on dedicated outputs. Addition and subtraction wrap modulo 2^64. The unit has no saturation and no overflow indication.

Top module: `mac_accum_unit`

## Requirements
- R1: A synchronous active-high reset clears both accumulator words, the result data and the result-valid flag to zero.
- R2: With `acc_en` high and nothing of higher priority in the same cycle, the 64-bit value {hi,lo} becomes {hi,lo} + sext64(P) at the next rising edge. P is bits 31:0 of the signed product `opnd_a` × `opnd_b`. Consecutive accumulates in consecutive cycles each take effect.
- R3: Only the low 32 bits of the product count, treated as signed. A product of 0x1_0000_0000 adds zero. A product of 0x8000_0000 adds 0xFFFF_FFFF_8000_0000.
- R4: With `sub_en` high and nothing of higher priority, {hi,lo} becomes {hi,lo} − sext64(P) at the next edge.
- R5: With `rdclr_en` high, at the next edge `res_data` holds the low word as it was before that edge, `res_valid` is 1 and both words are zero. In any cycle after a cycle without `rdclr_en`, `res_valid` is 0 and `res_data` keeps its last value.
- R6: `rdclr_en` has the highest priority. Any accumulate, subtract or direct write in the same cycle is ignored, and the accumulator still ends at zero.
- R7: `wr_lo` replaces only the low word with `wr_data`, and `wr_hi` replaces only the high word, at the next edge. Both together replace both words with the same value.
- R8: A direct write in the same cycle as an accumulate or subtract wins. The arithmetic is dropped, and a word that is not written keeps its value.
- R9: When `acc_en` and `sub_en` are both high, only the accumulate takes place.
- R10: The 64-bit sum and difference wrap modulo 2^64. For example, 0x7FFF_FFFF_FFFF_FFFF + 1 gives 0x8000_0000_0000_0000, and 0xFFFF_FFFF_FFFF_FFFF + 1 gives 0.
- R11: With no command and no write, both words hold their value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| acc_en | input | 1 | Accumulate command |
| sub_en | input | 1 | Multiply-subtract command |
| rdclr_en | input | 1 | Read-and-clear command |
| opnd_a | input | 32 | Signed multiplicand |
| opnd_b | input | 32 | Signed multiplier |
| wr_lo | input | 1 | Direct write of the low word |
| wr_hi | input | 1 | Direct write of the high word |
| wr_data | input | 32 | Data for direct writes |
| acc_lo | output | 32 | Low accumulator word |
| acc_hi | output | 32 | High accumulator word |
| res_data | output | 32 | Low word captured by the last read-and-clear |
| res_valid | output | 1 | High for one cycle after a read-and-clear |

## Verification
The cycle of interest is one in which a read-and-clear meets an accumulate, a subtract or a direct write. The bench drives these pairings on purpose. It also lets the random phase raise every command line independently, so that they overlap often. It judges the result with a priority-ordered bench model: the result port must carry the low word from before the edge, and both words must read zero afterwards. It also checks the plain accumulate that comes just before a read-and-clear, so that the value read out is the one already updated.

// File: rtl/mac_pkg.sv
package mac_pkg;

  // Action chosen for the accumulator in one cycle, after priority resolution
  typedef enum logic [2:0] {
    ACT_HOLD  = 3'd0,
    ACT_CLEAR = 3'd1,
    ACT_WRITE = 3'd2,
    ACT_ADD   = 3'd3,
    ACT_SUB   = 3'd4
  } acc_act_e;

endpackage

// File: rtl/mac_cmd_decode.sv
module mac_cmd_decode
  import mac_pkg::*;
(
  input  logic     acc_en,
  input  logic     sub_en,
  input  logic     rdclr_en,
  input  logic     wr_any,
  output acc_act_e act
);

  // Priority: clear > direct write > accumulate > subtract
  always_comb begin
    if (rdclr_en)    act = ACT_CLEAR;
    else if (wr_any) act = ACT_WRITE;
    else if (acc_en) act = ACT_ADD;
    else if (sub_en) act = ACT_SUB;
    else             act = ACT_HOLD;
  end

endmodule

// File: rtl/mac_product.sv
module mac_product #(
  parameter int DATA_W = 32,
  parameter int ACC_W  = 64
) (
  input  logic [DATA_W-1:0] mul_a,
  input  logic [DATA_W-1:0] mul_b,
  output logic [ACC_W-1:0]  addend
);

  localparam int FULL_W = 2 * DATA_W;
  localparam int EXT_W  = ACC_W - DATA_W;

  logic signed [FULL_W-1:0] a_x;
  logic signed [FULL_W-1:0] b_x;
  logic signed [FULL_W-1:0] full_prod;
  logic        [DATA_W-1:0] kept;

  assign a_x       = {{DATA_W{mul_a[DATA_W-1]}}, mul_a};
  assign b_x       = {{DATA_W{mul_b[DATA_W-1]}}, mul_b};
  assign full_prod = a_x * b_x;

  // Keep only the low word of the product, then widen it with its own sign
  assign kept   = full_prod[DATA_W-1:0];
  assign addend = {{EXT_W{kept[DATA_W-1]}}, kept};

endmodule

// File: rtl/mac_acc_reg.sv
module mac_acc_reg
  import mac_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int WORDS  = 2,
  parameter int ACC_W  = DATA_W * WORDS
) (
  input  logic              clk,
  input  logic              rst,
  input  acc_act_e          act,
  input  logic [WORDS-1:0]  wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ACC_W-1:0]  addend,
  output logic [ACC_W-1:0]  acc_q
);

  logic [ACC_W-1:0] merged;
  logic [ACC_W-1:0] acc_d;

  // Per-word replacement for direct writes
  for (genvar g = 0; g < WORDS; g++) begin : g_word
    assign merged[g*DATA_W +: DATA_W] =
      wr_en[g] ? wr_data : acc_q[g*DATA_W +: DATA_W];
  end

  always_comb begin
    case (act)
      ACT_CLEAR: acc_d = '0;
      ACT_WRITE: acc_d = merged;
      ACT_ADD:   acc_d = acc_q + addend;
      ACT_SUB:   acc_d = acc_q - addend;
      default:   acc_d = acc_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) acc_q <= '0;
    else     acc_q <= acc_d;
  end

endmodule

// File: rtl/mac_readout.sv
module mac_readout #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rdclr_en,
  input  logic [DATA_W-1:0] lo_word,
  output logic [DATA_W-1:0] res_data,
  output logic              res_valid
);

  always_ff @(posedge clk) begin
    if (rst) begin
      res_data  <= '0;
      res_valid <= 1'b0;
    end else begin
      res_valid <= rdclr_en;
      if (rdclr_en) res_data <= lo_word;
    end
  end

endmodule

// File: rtl/mac_accum_unit.sv
module mac_accum_unit
  import mac_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              acc_en,
  input  logic              sub_en,
  input  logic              rdclr_en,
  input  logic [DATA_W-1:0] opnd_a,
  input  logic [DATA_W-1:0] opnd_b,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] acc_lo,
  output logic [DATA_W-1:0] acc_hi,
  output logic [DATA_W-1:0] res_data,
  output logic              res_valid
);

  localparam int WORDS = 2;
  localparam int ACC_W = DATA_W * WORDS;

  acc_act_e         act;
  logic [ACC_W-1:0] addend;
  logic [ACC_W-1:0] acc_q;
  logic [WORDS-1:0] wr_en;

  assign wr_en = {wr_hi, wr_lo};

  mac_cmd_decode u_dec (
    .acc_en   (acc_en),
    .sub_en   (sub_en),
    .rdclr_en (rdclr_en),
    .wr_any   (|wr_en),
    .act      (act)
  );

  mac_product #(.DATA_W(DATA_W), .ACC_W(ACC_W)) u_prod (
    .mul_a  (opnd_a),
    .mul_b  (opnd_b),
    .addend (addend)
  );

  mac_acc_reg #(.DATA_W(DATA_W), .WORDS(WORDS), .ACC_W(ACC_W)) u_acc (
    .clk     (clk),
    .rst     (rst),
    .act     (act),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .addend  (addend),
    .acc_q   (acc_q)
  );

  assign acc_lo = acc_q[DATA_W-1:0];
  assign acc_hi = acc_q[ACC_W-1:DATA_W];

  mac_readout #(.DATA_W(DATA_W)) u_rd (
    .clk       (clk),
    .rst       (rst),
    .rdclr_en  (rdclr_en),
    .lo_word   (acc_lo),
    .res_data  (res_data),
    .res_valid (res_valid)
  );

endmodule

// File: rtl/mac_accum_unit_chk.sv
module mac_accum_unit_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              acc_en,
  input logic              sub_en,
  input logic              rdclr_en,
  input logic [DATA_W-1:0] opnd_a,
  input logic [DATA_W-1:0] opnd_b,
  input logic              wr_lo,
  input logic              wr_hi,
  input logic [DATA_W-1:0] wr_data,
  input logic [DATA_W-1:0] acc_lo,
  input logic [DATA_W-1:0] acc_hi,
  input logic [DATA_W-1:0] res_data,
  input logic              res_valid
);

  localparam int ACC_W = 2 * DATA_W;

  logic [ACC_W-1:0] acc_cat;
  logic [ACC_W-1:0] prod_lo_ext;
  logic [ACC_W-1:0] prod_u;

  assign acc_cat     = {acc_hi, acc_lo};
  assign prod_u      = {{DATA_W{1'b0}}, opnd_a} * {{DATA_W{1'b0}}, opnd_b};
  assign prod_lo_ext = {{DATA_W{prod_u[DATA_W-1]}}, prod_u[DATA_W-1:0]};

  AST_RESET_ZERO: assert property (@(posedge clk)
    rst |=> (acc_cat == '0 && !res_valid && res_data == '0)); // R1

  AST_ACC_STEP: assert property (@(posedge clk) disable iff (rst)
    (acc_en && !rdclr_en && !wr_lo && !wr_hi)
      |=> acc_cat == $past(acc_cat) + $past(prod_lo_ext)); // R2

  AST_SUB_STEP: assert property (@(posedge clk) disable iff (rst)
    (sub_en && !acc_en && !rdclr_en && !wr_lo && !wr_hi)
      |=> acc_cat == $past(acc_cat) - $past(prod_lo_ext)); // R4

  AST_RDCLR_ZERO: assert property (@(posedge clk) disable iff (rst)
    rdclr_en |=> (acc_cat == '0 && res_valid)); // R6

  AST_RDCLR_DATA: assert property (@(posedge clk) disable iff (rst)
    rdclr_en |=> res_data == $past(acc_lo)); // R5

  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (rst)
    !rdclr_en |=> (!res_valid && $stable(res_data))); // R5

  AST_WRITE_LO: assert property (@(posedge clk) disable iff (rst)
    (wr_lo && !rdclr_en) |=> acc_lo == $past(wr_data)); // R7

  AST_WRITE_HI_ONLY: assert property (@(posedge clk) disable iff (rst)
    (wr_hi && !wr_lo && !rdclr_en) |=> (acc_hi == $past(wr_data) && $stable(acc_lo))); // R8

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!acc_en && !sub_en && !rdclr_en && !wr_lo && !wr_hi) |=> $stable(acc_cat)); // R11

endmodule

bind mac_accum_unit mac_accum_unit_chk #(.DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .acc_en    (acc_en),
  .sub_en    (sub_en),
  .rdclr_en  (rdclr_en),
  .opnd_a    (opnd_a),
  .opnd_b    (opnd_b),
  .wr_lo     (wr_lo),
  .wr_hi     (wr_hi),
  .wr_data   (wr_data),
  .acc_lo    (acc_lo),
  .acc_hi    (acc_hi),
  .res_data  (res_data),
  .res_valid (res_valid)
);

// File: tb/mac_accum_unit_bench.sv
`timescale 1ns/1ps
module mac_accum_unit_bench;

  logic        clk = 1'b0;
  logic        rst;
  logic        acc_en, sub_en, rdclr_en, wr_lo, wr_hi;
  logic [31:0] opnd_a, opnd_b, wr_data;
  logic [31:0] acc_lo, acc_hi, res_data;
  logic        res_valid;

  int unsigned n_checks = 0;
  int unsigned n_errors = 0;
  bit          finished = 1'b0;

  logic [63:0] m_acc;
  logic [31:0] m_res;
  logic        m_val;

  always #2.5 clk = ~clk;

  mac_accum_unit u_mac_accum_unit (
    .clk(clk), .rst(rst), .acc_en(acc_en), .sub_en(sub_en), .rdclr_en(rdclr_en),
    .opnd_a(opnd_a), .opnd_b(opnd_b), .wr_lo(wr_lo), .wr_hi(wr_hi), .wr_data(wr_data),
    .acc_lo(acc_lo), .acc_hi(acc_hi), .res_data(res_data), .res_valid(res_valid)
  );

  // Signed product, low 32 bits kept, sign-extended to 64
  function automatic logic [63:0] trunc_ext(input logic [31:0] a, input logic [31:0] b);
    logic signed [63:0] full;
    full = $signed({{32{a[31]}}, a}) * $signed({{32{b[31]}}, b});
    return {{32{full[31]}}, full[31:0]};
  endfunction

  function automatic logic [63:0] next_acc(
    input logic [63:0] cur, input logic ae, input logic se, input logic rc,
    input logic wl, input logic wh, input logic [31:0] a, input logic [31:0] b,
    input logic [31:0] wd);
    logic [63:0] n;
    if (rc)            n = 64'd0;
    else if (wl || wh) n = {wh ? wd : cur[63:32], wl ? wd : cur[31:0]};
    else if (ae)       n = cur + trunc_ext(a, b);
    else if (se)       n = cur - trunc_ext(a, b);
    else               n = cur;
    return n;
  endfunction

  task automatic compare(input string tag);
    n_checks++;
    if ({acc_hi, acc_lo} !== m_acc || res_valid !== m_val || res_data !== m_res) begin
      n_errors++;
      $display("FAIL %s: acc=%h valid=%b res=%h expected acc=%h valid=%b res=%h",
               tag, {acc_hi, acc_lo}, res_valid, res_data, m_acc, m_val, m_res);
    end
  endtask

  task automatic drive(input logic ae, input logic se, input logic rc,
                       input logic wl, input logic wh, input logic [31:0] a,
                       input logic [31:0] b, input logic [31:0] wd, input string tag);
    acc_en = ae; sub_en = se; rdclr_en = rc; wr_lo = wl; wr_hi = wh;
    opnd_a = a; opnd_b = b; wr_data = wd;
    m_val = rc;
    if (rc) m_res = m_acc[31:0];
    m_acc = next_acc(m_acc, ae, se, rc, wl, wh, a, b, wd);
    @(posedge clk);
    @(negedge clk);
    compare(tag);
  endtask

  task automatic idle(input string tag);
    drive(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 32'd0, 32'd0, 32'd0, tag);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      n_errors++;
      n_checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] seed;
    seed = $urandom(32'h5eed_1234);
    acc_en = 0; sub_en = 0; rdclr_en = 0; wr_lo = 0; wr_hi = 0;
    opnd_a = 0; opnd_b = 0; wr_data = 0;
    rst = 1'b1;
    m_acc = 64'd0; m_res = 32'd0; m_val = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    compare("R1 reset state");
    rst = 1'b0;

    // R2 basic accumulate and sign handling
    drive(1, 0, 0, 0, 0, 32'd3, 32'd4, 0, "R2 acc 3*4");
    drive(1, 0, 0, 0, 0, -32'sd5, 32'd7, 0, "R2 acc -5*7");
    drive(1, 0, 0, 0, 0, 32'd100, 32'd2, 0, "R2 back-to-back acc");
    // R5 read-and-clear right after an accumulate
    drive(0, 0, 1, 0, 0, 0, 0, 0, "R5 read-and-clear after acc");
    idle("R5 valid drops");

    // R3 truncation
    drive(1, 0, 0, 0, 0, 32'h0001_0000, 32'h0001_0000, 0, "R3 product 2^32 adds zero");
    drive(1, 0, 0, 0, 0, 32'h0000_8000, 32'h0001_0000, 0, "R3 product 2^31 negative");
    // R4 subtract
    drive(0, 0, 1, 0, 0, 0, 0, 0, "R5 clear before subtract");
    drive(0, 1, 0, 0, 0, 32'd2, 32'd3, 0, "R4 sub 2*3");
    drive(0, 1, 0, 0, 0, -32'sd4, 32'd5, 0, "R4 sub -4*5");

    // R7 direct writes
    drive(0, 0, 0, 1, 0, 0, 0, 32'h1234_5678, "R7 write low only");
    drive(0, 0, 0, 0, 1, 0, 0, 32'h0000_0abc, "R7 write high only");
    drive(0, 0, 0, 1, 1, 0, 0, 32'hcafe_f00d, "R7 write both");
    // R8 write beats arithmetic
    drive(1, 0, 0, 1, 0, 32'd9, 32'd9, 32'h0000_0011, "R8 write low with acc");
    drive(0, 1, 0, 0, 1, 32'd9, 32'd9, 32'h0000_0022, "R8 write high with sub");
    // R9 accumulate beats subtract
    drive(1, 1, 0, 0, 0, 32'd6, 32'd7, 0, "R9 acc and sub together");
    // R11 hold
    idle("R11 idle hold");
    // R6 read-and-clear with everything else in the same cycle
    drive(1, 1, 1, 1, 1, 32'd5, 32'd5, 32'hdead_beef, "R6 clear beats all");
    drive(0, 0, 0, 1, 0, 0, 0, 32'h0bad_f00d, "R6 reload low");
    drive(1, 0, 1, 0, 0, 32'd8, 32'd8, 0, "R6 clear with acc");
    // R10 wrap
    drive(0, 0, 0, 1, 1, 0, 0, 32'hffff_ffff, "R10 load all ones");
    drive(0, 0, 0, 0, 1, 0, 0, 32'h7fff_ffff, "R10 load high 7fffffff");
    drive(1, 0, 0, 0, 0, 32'd1, 32'd1, 0, "R10 signed boundary wrap");
    drive(0, 0, 0, 1, 1, 0, 0, 32'hffff_ffff, "R10 reload all ones");
    drive(1, 0, 0, 0, 0, 32'd1, 32'd1, 0, "R10 wrap to zero");
    drive(0, 1, 0, 0, 0, 32'd1, 32'd1, 0, "R10 sub wraps below zero");

    // Constrained random mix; the command lines overlap often
    for (int i = 0; i < 600; i++) begin
      logic ae, se, rc, wl, wh;
      logic [31:0] a, b, wd;
      ae = ($urandom % 100) < 50;
      se = ($urandom % 100) < 30;
      rc = ($urandom % 100) < 12;
      wl = ($urandom % 100) < 8;
      wh = ($urandom % 100) < 8;
      a  = ($urandom % 4 == 0) ? {$urandom % 2 == 0 ? 16'h8000 : 16'h7fff, 16'($urandom)} : $urandom;
      b  = ($urandom % 4 == 0) ? 32'($urandom % 9) - 32'd4 : $urandom;
      wd = $urandom;
      drive(ae, se, rc, wl, wh, a, b, wd, "R2 R4 R6 random mix");
    end

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

endmodule